// File: doc/BRIEF.md
# Strap-Latched Clock Control Register Bank

This block is a four-byte control register bank that a serial-bus engine reads and writes one byte at a time. It governs two things for a differential clock buffer: which bandwidth mode the PLL runs in, and which of the eight differential outputs are allowed to drive. Shortly after power-up a one-shot strobe captures the mode and frequency-select strap pins. Software can always read those captured values back, but it cannot write them.

An override bit chooses the source of the effective PLL mode. When the bit is 0, the captured strap sets the mode. When the bit is 1, a pair of writable register bits sets it. In both cases the strap readback keeps the value it captured. Each output also has an enable bit, and that bit is combined with the output's active-low enable pin. Clearing the bit turns the output off whatever the pin does.

Writes take effect at the next clock edge. Reads are combinational from the addressed byte. The bank only produces the control signals. Acting on a mode change, or applying the warm reset it needs, is done outside the block.

Top module: `clkctl_regs`

## Requirements
- R1: After reset, with no strobe seen yet, the bytes read: byte 0 = 0x06, byte 1 = 0xFF, byte 2 = 0x0F, byte 3 = 0x00. The captured strap and frequency bits read 0, the override bit reads 0 and the mode bits read 11.
- R2: The first strobe after reset captures the 2-bit mode strap into byte 0 bits 7:6 and the frequency strap into byte 0 bit 0. In bit 0, a value of 1 means 100 MHz and 0 means 133 MHz.
- R3: Strap capture happens once per reset. Later strobes and strap changes leave byte 0 bits 7:6 and 0 unchanged until the next reset, after which a strobe captures again.
- R4: When byte 0 bit 3 (override) is 0, the PLL mode output equals the captured strap in byte 0 bits 7:6.
- R5: When byte 0 bit 3 is 1, the PLL mode output equals byte 0 bits 2:1, and bits 7:6 still read the captured strap.
- R6: Writes to read-only or reserved bits are ignored. Byte 0 bits 7:4 and 0 are unaffected. Byte 1 bits 3 and 0 always read 1. Byte 2 bits 3 and 1 always read 1 and bits 7:4 always read 0. Byte 3 always reads 0x00.
- R7: The enable bits map to outputs 0..5 through byte 1 bits 1, 2, 4, 5, 6, 7, and to outputs 6 and 7 through byte 2 bits 0 and 2. Output k is enabled exactly when its enable bit is 1 and its pin oe_n[k] is 0.
- R8: An enable bit of 0 keeps its output disabled whatever the level of its oe_n pin.
- R9: A write is visible on rdata and on the outputs only after the clock edge that samples it. rdata follows addr with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe from the serial engine |
| addr | input | 2 | Byte index, 0 to 3 |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Combinational read of the addressed byte |
| strap_mode | input | 2 | PLL mode strap pins |
| strap_freq | input | 1 | Frequency-select strap pin (1 = 100 MHz) |
| latch_stb | input | 1 | Power-up strap capture strobe |
| oe_n | input | 8 | Active-low output-enable pins, one per output |
| pll_mode | output | 2 | Effective PLL bandwidth mode |
| out_en | output | 8 | Effective per-output enable |

## Verification
The properties assume that addr, wr_en, wdata, oe_n and the strap inputs are synchronous to clk and stable around each rising edge. They also assume that rdata is observed combinationally for the address presented in that cycle. The stimulus respects this by changing every input one nanosecond after a rising edge and sampling on the falling edge. The stimulus deliberately fires the strobe a second time, with different strap values, to exercise the one-shot capture. It also applies a second reset in the middle of the run to confirm that capture is armed again.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
   localparam int BYTE_W   = 8;
   localparam int NUM_OUT  = 8;
   localparam int MODE_W   = 2;

   // Byte indices decoded by software
   localparam int IDX_MODE = 0;
   localparam int IDX_ENA  = 1;
   localparam int IDX_ENB  = 2;

   // Fixed values of reserved positions
   localparam logic [BYTE_W-1:0] ENA_FIXED = 8'h09;
   localparam logic [BYTE_W-1:0] ENB_FIXED = 8'h0A;

   // Bit positions inside byte 0
   localparam int POS_FREQ = 0;
   localparam int POS_MLO  = 1;
   localparam int POS_OVR  = 3;
   localparam int POS_SLO  = 6;

   // Byte holding the enable bit of output k
   function automatic int en_byte(input int k);
      return (k < 6) ? IDX_ENA : IDX_ENB;
   endfunction

   // Bit position of output k's enable inside its byte
   function automatic int en_bit(input int k);
      if (k < 2)      return k + 1;
      else if (k < 6) return k + 2;
      else            return (k - 6) * 2;
   endfunction
endpackage

// File: rtl/clkctl_strap_latch.sv
module clkctl_strap_latch #(
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic [MODE_W-1:0] mode_in,
   input  logic              freq_in,
   output logic [MODE_W-1:0] mode_q,
   output logic              freq_q
);
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         mode_q  <= '0;
         freq_q  <= 1'b0;
      end else if (stb && armed_q) begin
         armed_q <= 1'b0;
         mode_q  <= mode_in;
         freq_q  <= freq_in;
      end
   end
endmodule

// File: rtl/clkctl_regfile.sv
module clkctl_regfile
   import clkctl_pkg::*;
#(
   parameter int              ADDR_W   = 2,
   parameter int              DATA_W   = 8,
   parameter int              N_OUT    = 8,
   parameter int              MODE_W   = 2,
   parameter logic [MODE_W-1:0] MODE_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [MODE_W-1:0] strap_mode,
   input  logic              strap_freq,
   output logic [DATA_W-1:0] rdata,
   output logic              ovr_q,
   output logic [MODE_W-1:0] mode_q,
   output logic [N_OUT-1:0]  en_q
);
   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(IDX_MODE);
   localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(IDX_ENA);
   localparam logic [ADDR_W-1:0] A_ENB  = ADDR_W'(IDX_ENB);

   logic wr_mode;
   assign wr_mode = wr_en && (addr == A_MODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q  <= 1'b0;
         mode_q <= MODE_RST;
      end else if (wr_mode) begin
         ovr_q  <= wdata[POS_OVR];
         mode_q <= wdata[POS_MLO +: MODE_W];
      end
   end

   for (genvar k = 0; k < N_OUT; k++) begin : g_en
      localparam logic [ADDR_W-1:0] A_K = ADDR_W'(en_byte(k));
      localparam int                B_K = en_bit(k);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      en_q[k] <= 1'b1;
         else if (wr_en && addr == A_K)   en_q[k] <= wdata[B_K];
      end
   end

   logic [DATA_W-1:0] b_mode, b_ena, b_enb;

   always_comb begin
      b_mode                       = '0;
      b_mode[POS_SLO +: MODE_W]    = strap_mode;
      b_mode[POS_OVR]              = ovr_q;
      b_mode[POS_MLO +: MODE_W]    = mode_q;
      b_mode[POS_FREQ]             = strap_freq;
      b_ena = ENA_FIXED;
      b_enb = ENB_FIXED;
      for (int k = 0; k < N_OUT; k++) begin
         if (en_byte(k) == IDX_ENA) b_ena[en_bit(k)] = en_q[k];
         else                       b_enb[en_bit(k)] = en_q[k];
      end
   end

   always_comb begin
      unique case (addr)
         A_MODE:  rdata = b_mode;
         A_ENA:   rdata = b_ena;
         A_ENB:   rdata = b_enb;
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/clkctl_oe_gate.sv
module clkctl_oe_gate #(
   parameter int N_OUT  = 8,
   parameter int MODE_W = 2
) (
   input  logic              ovr,
   input  logic [MODE_W-1:0] mode_reg,
   input  logic [MODE_W-1:0] mode_strap,
   input  logic [N_OUT-1:0]  en,
   input  logic [N_OUT-1:0]  oe_n,
   output logic [MODE_W-1:0] pll_mode,
   output logic [N_OUT-1:0]  out_en
);
   assign pll_mode = ovr ? mode_reg : mode_strap;

   for (genvar k = 0; k < N_OUT; k++) begin : g_gate
      assign out_en[k] = en[k] & ~oe_n[k];
   end
endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
   import clkctl_pkg::*;
#(
   parameter int                ADDR_W   = 2,
   parameter int                DATA_W   = BYTE_W,
   parameter int                N_OUT    = NUM_OUT,
   parameter int                MODE_W   = clkctl_pkg::MODE_W,
   parameter logic [MODE_W-1:0] MODE_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [MODE_W-1:0] strap_mode,
   input  logic              strap_freq,
   input  logic              latch_stb,
   input  logic [N_OUT-1:0]  oe_n,
   output logic [MODE_W-1:0] pll_mode,
   output logic [N_OUT-1:0]  out_en
);
   if (DATA_W != BYTE_W) begin : g_bad_width
      $error("clkctl_regs: DATA_W must be %0d", BYTE_W);
   end
   if (N_OUT != NUM_OUT) begin : g_bad_outs
      $error("clkctl_regs: N_OUT must be %0d", NUM_OUT);
   end
   if (MODE_W != clkctl_pkg::MODE_W) begin : g_bad_mode
      $error("clkctl_regs: MODE_W must be %0d", clkctl_pkg::MODE_W);
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("clkctl_regs: ADDR_W must cover four bytes");
   end

   logic [MODE_W-1:0] strap_mode_q;
   logic              strap_freq_q;
   logic              ovr_q;
   logic [MODE_W-1:0] mode_q;
   logic [N_OUT-1:0]  en_q;

   clkctl_strap_latch #(.MODE_W(MODE_W)) u_strap (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb     (latch_stb),
      .mode_in (strap_mode),
      .freq_in (strap_freq),
      .mode_q  (strap_mode_q),
      .freq_q  (strap_freq_q)
   );

   clkctl_regfile #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .N_OUT   (N_OUT),
      .MODE_W  (MODE_W),
      .MODE_RST(MODE_RST)
   ) u_rf (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .addr       (addr),
      .wdata      (wdata),
      .strap_mode (strap_mode_q),
      .strap_freq (strap_freq_q),
      .rdata      (rdata),
      .ovr_q      (ovr_q),
      .mode_q     (mode_q),
      .en_q       (en_q)
   );

   clkctl_oe_gate #(.N_OUT(N_OUT), .MODE_W(MODE_W)) u_gate (
      .ovr        (ovr_q),
      .mode_reg   (mode_q),
      .mode_strap (strap_mode_q),
      .en         (en_q),
      .oe_n       (oe_n),
      .pll_mode   (pll_mode),
      .out_en     (out_en)
   );
endmodule

// File: rtl/clkctl_regs_chk.sv
module clkctl_regs_chk #(
   parameter int ADDR_W = 2,
   parameter int N_OUT  = 8,
   parameter int MODE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        wdata,
   input logic [7:0]        rdata,
   input logic              latch_stb,
   input logic [N_OUT-1:0]  oe_n,
   input logic [MODE_W-1:0] pll_mode,
   input logic [N_OUT-1:0]  out_en
);
   logic seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         seen_q <= 1'b0;
      else if (latch_stb) seen_q <= 1'b1;
   end

   AST_BYTE3_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(3)) |-> (rdata == 8'h00)); // R6

   AST_ENA_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(1)) |-> (rdata[3] && rdata[0])); // R6

   AST_ENB_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(2)) |-> (rdata[7:4] == 4'h0 && rdata[3] && rdata[1])); // R6

   AST_MODE_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(0) && !rdata[3]) |-> (pll_mode == rdata[7:6])); // R4

   AST_MODE_OVR: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(0) && rdata[3]) |-> (pll_mode == rdata[2:1])); // R5

   AST_PIN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_en & oe_n) == '0)); // R7

   AST_EN_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(1) && !wdata[1]) |=> !out_en[0]); // R8

   AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(0) && $past(addr == ADDR_W'(0)) && $past(seen_q))
      |-> (rdata[7:6] == $past(rdata[7:6]) && rdata[0] == $past(rdata[0]))); // R3
endmodule

bind clkctl_regs clkctl_regs_chk #(
   .ADDR_W(ADDR_W), .N_OUT(N_OUT), .MODE_W(MODE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .rdata(rdata), .latch_stb(latch_stb), .oe_n(oe_n),
   .pll_mode(pll_mode), .out_en(out_en)
);

// File: tb/clkctl_regs_bench.sv
`timescale 1ns/100ps
module clkctl_regs_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic [1:0] strap_mode = 2'b00;
   logic       strap_freq = 1'b0;
   logic       latch_stb = 1'b0;
   logic [7:0] oe_n = 8'h00;
   logic [1:0] pll_mode;
   logic [7:0] out_en;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   clkctl_regs u_clkctl_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .strap_mode(strap_mode), .strap_freq(strap_freq),
      .latch_stb(latch_stb), .oe_n(oe_n), .pll_mode(pll_mode), .out_en(out_en)
   );

   // Behavioural reference model
   bit [1:0] m_strap;
   bit       m_freq, m_taken, m_ovr;
   bit [1:0] m_mode;
   bit       m_en [8];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_strap = 0; m_freq = 0; m_taken = 0; m_ovr = 0; m_mode = 2'b11;
         foreach (m_en[i]) m_en[i] = 1;
      end else begin
         if (latch_stb && !m_taken) begin
            m_strap = strap_mode; m_freq = strap_freq; m_taken = 1;
         end
         if (wr_en) begin
            case (addr)
               2'd0: begin m_ovr = wdata[3]; m_mode = wdata[2:1]; end
               2'd1: begin
                  m_en[0] = wdata[1]; m_en[1] = wdata[2]; m_en[2] = wdata[4];
                  m_en[3] = wdata[5]; m_en[4] = wdata[6]; m_en[5] = wdata[7];
               end
               2'd2: begin m_en[6] = wdata[0]; m_en[7] = wdata[2]; end
               default: ;
            endcase
         end
      end
   end

   function automatic logic [7:0] m_read(input logic [1:0] a);
      case (a)
         2'd0: return {m_strap, 2'b00, m_ovr, m_mode, m_freq};
         2'd1: return {m_en[5], m_en[4], m_en[3], m_en[2], 1'b1, m_en[1], m_en[0], 1'b1};
         2'd2: return {4'h0, 1'b1, m_en[7], 1'b1, m_en[6]};
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] m_outs();
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = m_en[i] && !oe_n[i];
      return r;
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R9 rdata", rdata, m_read(addr));
         chk(m_ovr ? "R5 pll_mode" : "R4 pll_mode", {6'd0, pll_mode},
             {6'd0, (m_ovr ? m_mode : m_strap)});
         chk("R7 out_en", out_en, m_outs());
      end
   end

   task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
      @(posedge clk); #1; addr = a;
      @(negedge clk); chk(tag, rdata, exp);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(posedge clk); #1; wr_en = 1; addr = a; wdata = d;
      @(posedge clk); #1; wr_en = 0;
   endtask

   task automatic pulse_stb();
      @(posedge clk); #1; latch_stb = 1;
      @(posedge clk); #1; latch_stb = 0;
   endtask

   task automatic out_chk(input logic [7:0] exp, input string tag);
      @(negedge clk); chk(tag, out_en, exp);
   endtask

   task automatic do_reset();
      @(posedge clk); #1; rst_n = 0;
      repeat (2) @(posedge clk);
      #1; rst_n = 1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1; rst_n = 1;
      // R1 reset values
      rd(2'd0, 8'h06, "R1 byte0");
      rd(2'd1, 8'hFF, "R1 byte1");
      rd(2'd2, 8'h0F, "R1 byte2");
      rd(2'd3, 8'h00, "R1 byte3");
      // R2 capture
      strap_mode = 2'b10; strap_freq = 1;
      pulse_stb();
      rd(2'd0, 8'h87, "R2 capture");
      @(negedge clk); chk("R4 strap mode", {6'd0, pll_mode}, 8'h02);
      // R3 second strobe ignored
      strap_mode = 2'b01; strap_freq = 0;
      pulse_stb();
      rd(2'd0, 8'h87, "R3 one-shot");
      // R5 override, R6 read-only bits in byte 0
      wr(2'd0, 8'hFF);
      rd(2'd0, 8'h8F, "R6 byte0 ro");
      @(negedge clk); chk("R5 ovr 11", {6'd0, pll_mode}, 8'h03);
      wr(2'd0, 8'h0A);
      rd(2'd0, 8'h8B, "R5 readback kept");
      @(negedge clk); chk("R5 ovr 01", {6'd0, pll_mode}, 8'h01);
      wr(2'd0, 8'h00);
      @(negedge clk); chk("R4 back to strap", {6'd0, pll_mode}, 8'h02);
      // R6 reserved bits
      wr(2'd1, 8'h00); rd(2'd1, 8'h09, "R6 byte1 rsvd");
      wr(2'd2, 8'hFF); rd(2'd2, 8'h0F, "R6 byte2 ones");
      wr(2'd2, 8'h00); rd(2'd2, 8'h0A, "R6 byte2 zeros");
      wr(2'd3, 8'hFF); rd(2'd3, 8'h00, "R6 byte3");
      // R8 all enables cleared, pins asserted
      oe_n = 8'h00;
      out_chk(8'h00, "R8 all off");
      // R7 bit mapping, one output at a time
      for (int k = 0; k < 8; k++) begin
         logic [1:0] a;
         logic [7:0] d;
         a = (k < 6) ? 2'd1 : 2'd2;
         case (k)
            0: d = 8'h02; 1: d = 8'h04; 2: d = 8'h10; 3: d = 8'h20;
            4: d = 8'h40; 5: d = 8'h80; 6: d = 8'h01; default: d = 8'h04;
         endcase
         wr(a, d);
         out_chk(8'(1 << k), "R7 map");
         wr(a, 8'h00);
      end
      // R7 pin gating with all enables on
      wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
      @(posedge clk); #1; oe_n = 8'hA5;
      out_chk(8'h5A, "R7 pins");
      // R8 cleared bit beats released pin
      @(posedge clk); #1; oe_n = 8'h00;
      wr(2'd1, 8'hD6);
      out_chk(8'hF7, "R8 forced off");
      // R9 write visible only after the edge
      @(posedge clk); #1; wr_en = 1; addr = 2'd0; wdata = 8'h08;
      @(negedge clk); chk("R9 before edge", rdata, 8'h81);
      @(posedge clk); #1; wr_en = 0;
      @(negedge clk); chk("R9 after edge", rdata, 8'h89);
      // R3 capture rearmed by reset
      do_reset();
      rd(2'd0, 8'h06, "R3 reset clears");
      strap_mode = 2'b01; strap_freq = 0;
      pulse_stb();
      rd(2'd0, 8'h46, "R3 recapture");
      repeat (2) @(posedge clk);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule